// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block sits between two DMA channels and a single external bus master port. Software programs each channel with an enable, a priority level, a 32-bit external address and a 16-bit byte count through a small word-addressed register interface. The arbiter then hands the port one block at a time. A block is never larger than a fixed maximum size. After each block completes, the arbiter advances the served channel's address and reduces its remaining length.

Contention is settled in two steps. A channel marked high priority beats a channel marked low priority. Two channels at the same level take turns. Software can read which channels are still busy and which channel the port served last. A bus error seen during a block is latched in a sticky flag. A self-clearing soft reset disables both channels, and software knows the reset has finished when both busy flags read low.

Top module: `dual_dma_arbiter`

## Requirements
- R1: After the asynchronous reset, every readable register returns 0 and the port request `blk_req` is low.
- R2: Register map in word addresses. Channel n uses word 4n for control (bit0 enable, bit1 high priority), word 4n+1 for the address and word 4n+2 for the length (bits 15:0). A transfer starts only when a non-zero length is written while that channel's enable bit is already set. Writing a length to a disabled channel only stores the value. Writing a zero length starts nothing, and so does setting the enable afterwards.
- R3: When both channels request and their priority bits differ, the high-priority channel is granted.
- R4: When both channels request with equal priority, the grant goes to the channel named by a round-robin pointer. The pointer is 0 after any reset and toggles only on such a contested grant.
- R5: Each block carries min(remaining length, 16) bytes. When the block completes, the channel's address register reads back increased by that count and its length register reads back reduced by it.
- R6: A channel becomes inactive once its remaining length reaches zero.
- R7: Clearing the enable of a channel whose block is in flight does not cut that block short. Its request stays up with unchanged fields until `blk_done`, and no further block is requested for that channel.
- R8: Status word 8 reads bit0 = channel 0 active, bit1 = channel 1 active, bit4 = channel of the most recently completed block, bit8 = port error.
- R9: Writing 1 to bit0 of word 9 triggers a soft reset, and word 9 reads 0. The soft reset clears both enables, the round-robin pointer and the port error. A block already in flight finishes, and its channel's active bit stays high until that block is done.
- R10: `bus_err` high while a block is in flight sets the port error flag. The flag stays set until a reset or soft reset.
- R11: `blk_req` stays high with stable `blk_ch`, `blk_addr` and `blk_bytes` from the grant until the cycle in which `blk_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| blk_req | output | 1 | Block in flight on the master port |
| blk_ch | output | 1 | Channel owning the block |
| blk_addr | output | 32 | External start address of the block |
| blk_bytes | output | 5 | Byte count of the block |
| blk_done | input | 1 | Master port finished the block |
| bus_err | input | 1 | Bus error reported by the master port |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit length and a 16-byte block limit. With those values, lengths of 20, 40 and 48 bytes give short sequences that cover full blocks, a short tail block and a round-robin run of six grants. A table of priority pairs drives a contested second grant for each priority combination. Directed cases then cover disabling a channel mid-block, soft reset with a block in flight, and the sticky bus error.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam logic [3:0] REG_STATUS = 4'd8;
  localparam logic [3:0] REG_SRESET = 4'd9;

  typedef enum logic {PS_IDLE = 1'b0, PS_BUSY = 1'b1} port_state_e;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_addr,
  input  logic          wr_len,
  input  logic [1:0]    wd_ctl,
  input  logic [AW-1:0] wd_addr,
  input  logic [LW-1:0] wd_len,
  input  logic          soft_rst,
  input  logic          inflight,
  input  logic          done,
  input  logic [BW-1:0] blk_bytes,
  output logic          en_o,
  output logic          prio_o,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  output logic          active_o,
  output logic          req_o
);
  logic          en_q, en_d;
  logic          prio_q, prio_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] len_q, len_d;
  logic          act_q, act_d;
  logic [LW-1:0] len_after;

  always_comb begin
    len_after = (len_q > LW'(blk_bytes)) ? (len_q - LW'(blk_bytes)) : '0;

    en_d   = en_q;
    prio_d = prio_q;
    if (soft_rst) begin
      en_d   = 1'b0;
      prio_d = 1'b0;
    end else if (wr_ctl) begin
      en_d   = wd_ctl[0];
      prio_d = wd_ctl[1];
    end

    addr_d = addr_q;
    if (wr_addr)   addr_d = wd_addr;
    else if (done) addr_d = addr_q + AW'(blk_bytes);

    len_d = len_q;
    if (wr_len)    len_d = wd_len;
    else if (done) len_d = len_after;

    act_d = act_q;
    if (soft_rst)                          act_d = act_q & inflight;
    else if (done)                         act_d = (len_after != '0) & en_q;
    else if (wr_len && en_q && wd_len != '0) act_d = 1'b1;
    else if (!en_q && !inflight)           act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      prio_q <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      prio_q <= prio_d;
      addr_q <= addr_d;
      len_q  <= len_d;
      act_q  <= act_d;
    end
  end

  assign en_o     = en_q;
  assign prio_o   = prio_q;
  assign addr_o   = addr_q;
  assign len_o    = len_q;
  assign active_o = act_q;
  assign req_o    = act_q & en_q;

  // R7: a disabled channel with nothing in flight goes idle
  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !inflight) |=> !act_q);

  // R6: a channel whose length ran out is no longer active
  a_r6_empty_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_len && len_q <= LW'(blk_bytes)) |=> !act_q);

  // R2: a length write to a disabled channel never activates it
  a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_len && !en_q && !act_q && !inflight) |=> !act_q);
endmodule

// File: rtl/dma2_pick.sv
module dma2_pick (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic [1:0] prio,
  input  logic       rr,
  output logic       gnt_valid,
  output logic       gnt_ch,
  output logic       contest
);
  always_comb begin
    gnt_valid = |req;
    contest   = (&req) && (prio[0] == prio[1]);
    if (&req) gnt_ch = (prio[0] != prio[1]) ? prio[1] : rr;
    else      gnt_ch = req[1];
  end

  // R3: with mixed priority the high-priority requester wins
  a_r3_high_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((&req) && (prio[0] != prio[1])) |-> prio[gnt_ch]);

  // R4: a grant always goes to a requesting channel
  a_r4_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_ch]);
endmodule

// File: rtl/dma2_port.sv
module dma2_port
  import dma2_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int BW  = 5,
  parameter int BLK = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          gnt_valid,
  input  logic          gnt_ch,
  input  logic          contest,
  input  logic [LW-1:0] len0,
  input  logic [LW-1:0] len1,
  input  logic [AW-1:0] addr0,
  input  logic [AW-1:0] addr1,
  input  logic          blk_done,
  input  logic          bus_err,
  output logic          blk_req,
  output logic          blk_ch,
  output logic [AW-1:0] blk_addr,
  output logic [BW-1:0] blk_bytes,
  output logic [1:0]    done_vec,
  output logic [1:0]    inflight_vec,
  output logic          last_ch,
  output logic          port_err,
  output logic          rr
);
  port_state_e   st_q, st_d;
  logic          ch_q, last_q, err_q, rr_q, rr_d, err_d;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bytes_q, bytes_d;
  logic          issue, finish;
  logic [LW-1:0] sel_len;

  always_comb begin
    issue   = (st_q == PS_IDLE) && gnt_valid;
    finish  = (st_q == PS_BUSY) && blk_done;
    sel_len = gnt_ch ? len1 : len0;
    bytes_d = (sel_len > LW'(BLK)) ? BW'(BLK) : BW'(sel_len);

    st_d = st_q;
    if (issue)       st_d = PS_BUSY;
    else if (finish) st_d = PS_IDLE;

    rr_d = rr_q;
    if (soft_rst)              rr_d = 1'b0;
    else if (issue && contest) rr_d = ~gnt_ch;

    err_d = err_q;
    if (soft_rst)                              err_d = 1'b0;
    else if ((st_q == PS_BUSY) && bus_err)     err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_IDLE;
      ch_q    <= 1'b0;
      addr_q  <= '0;
      bytes_q <= '0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      rr_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      rr_q  <= rr_d;
      err_q <= err_d;
      if (issue) begin
        ch_q    <= gnt_ch;
        addr_q  <= gnt_ch ? addr1 : addr0;
        bytes_q <= bytes_d;
      end
      if (finish) last_q <= ch_q;
    end
  end

  assign blk_req      = (st_q == PS_BUSY);
  assign blk_ch       = ch_q;
  assign blk_addr     = addr_q;
  assign blk_bytes    = bytes_q;
  assign done_vec     = {finish & ch_q, finish & ~ch_q};
  assign inflight_vec = {blk_req & ch_q, blk_req & ~ch_q};
  assign last_ch      = last_q;
  assign port_err     = err_q;
  assign rr           = rr_q;

  // R11: block fields hold until the port reports completion
  a_r11_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req && !blk_done) |=> (blk_req && $stable(blk_ch) && $stable(blk_addr) && $stable(blk_bytes)));

  // R5: block size is non-zero and bounded by the block limit
  a_r5_block_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |-> (blk_bytes != '0 && blk_bytes <= BW'(BLK)));

  // R10: the port error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (port_err && !soft_rst) |=> port_err);

  // R4: a contested grant moves the pointer away from the winner
  a_r4_rr_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && contest && !soft_rst) |=> (rr_q != $past(gnt_ch)));

  // R8: last-served field follows the completed block
  a_r8_last_served: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (last_ch == $past(ch_q)));
endmodule

// File: rtl/dual_dma_arbiter.sv
module dual_dma_arbiter
  import dma2_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        blk_req,
  output logic        blk_ch,
  output logic [31:0] blk_addr,
  output logic [4:0]  blk_bytes,
  input  logic        blk_done,
  input  logic        bus_err
);
  localparam int BW = $clog2(BLK_BYTES + 1);

  logic          soft_rst;
  logic [1:0]    en, prio, active, req, done_vec, inflight_vec;
  logic [AW-1:0] ch_addr [2];
  logic [LW-1:0] ch_len  [2];
  logic          gnt_valid, gnt_ch, contest, rr, last_ch, port_err;
  logic [BW-1:0] bytes_w;
  logic [AW-1:0] addr_w;

  assign soft_rst = cfg_we && (cfg_addr == REG_SRESET) && cfg_wdata[0];

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic sel;
    assign sel = cfg_we && (cfg_addr[3:2] == 2'(i));
    dma2_chan #(.AW(AW), .LW(LW), .BW(BW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (sel && cfg_addr[1:0] == 2'd0),
      .wr_addr   (sel && cfg_addr[1:0] == 2'd1),
      .wr_len    (sel && cfg_addr[1:0] == 2'd2),
      .wd_ctl    (cfg_wdata[1:0]),
      .wd_addr   (cfg_wdata[AW-1:0]),
      .wd_len    (cfg_wdata[LW-1:0]),
      .soft_rst  (soft_rst),
      .inflight  (inflight_vec[i]),
      .done      (done_vec[i]),
      .blk_bytes (bytes_w),
      .en_o      (en[i]),
      .prio_o    (prio[i]),
      .addr_o    (ch_addr[i]),
      .len_o     (ch_len[i]),
      .active_o  (active[i]),
      .req_o     (req[i])
    );
  end

  dma2_pick u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .prio      (prio),
    .rr        (rr),
    .gnt_valid (gnt_valid),
    .gnt_ch    (gnt_ch),
    .contest   (contest)
  );

  dma2_port #(.AW(AW), .LW(LW), .BW(BW), .BLK(BLK_BYTES)) u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .gnt_valid    (gnt_valid),
    .gnt_ch       (gnt_ch),
    .contest      (contest),
    .len0         (ch_len[0]),
    .len1         (ch_len[1]),
    .addr0        (ch_addr[0]),
    .addr1        (ch_addr[1]),
    .blk_done     (blk_done),
    .bus_err      (bus_err),
    .blk_req      (blk_req),
    .blk_ch       (blk_ch),
    .blk_addr     (addr_w),
    .blk_bytes    (bytes_w),
    .done_vec     (done_vec),
    .inflight_vec (inflight_vec),
    .last_ch      (last_ch),
    .port_err     (port_err),
    .rr           (rr)
  );

  assign blk_addr  = 32'(addr_w);
  assign blk_bytes = 5'(bytes_w);

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_addr[3]) begin
      case (cfg_addr[1:0])
        2'd0:    cfg_rdata = {30'b0, prio[cfg_addr[2]], en[cfg_addr[2]]};
        2'd1:    cfg_rdata = 32'(ch_addr[cfg_addr[2]]);
        2'd2:    cfg_rdata = 32'(ch_len[cfg_addr[2]]);
        default: cfg_rdata = '0;
      endcase
    end else if (cfg_addr == REG_STATUS) begin
      cfg_rdata = {23'b0, port_err, 3'b0, last_ch, 2'b0, active};
    end
  end

  // R9: soft reset leaves both channels disabled on the next cycle
  a_r9_sreset_disables: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (en == 2'b00));
endmodule

// File: tb/dual_dma_arbiter_test.sv
`timescale 1ns/100ps
module dual_dma_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        blk_req, blk_ch, blk_done, bus_err;
  logic [31:0] blk_addr;
  logic [4:0]  blk_bytes;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_dma_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .blk_req(blk_req),
    .blk_ch(blk_ch), .blk_addr(blk_addr), .blk_bytes(blk_bytes),
    .blk_done(blk_done), .bus_err(bus_err)
  );

  // {prio0, prio1, expected second-grant channel}
  localparam logic [2:0] ROWS [4] = '{3'b000, 3'b110, 3'b100, 3'b011};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
  endtask

  task automatic await_req();
    for (int i = 0; i < 20 && !blk_req; i++) @(negedge clk);
  endtask

  task automatic pulse_done();
    blk_done = 1'b1;
    @(negedge clk);
    blk_done = 1'b0;
  endtask

  task automatic serve(input logic ech, input logic [31:0] eaddr, input logic [4:0] ebytes, input string tag);
    await_req();
    chk(blk_req === 1'b1, {tag, " req"}, 32'(blk_req), 32'h1);
    chk(blk_ch === ech, {tag, " ch"}, 32'(blk_ch), 32'(ech));
    chk(blk_addr === eaddr, {tag, " addr"}, blk_addr, eaddr);
    chk(blk_bytes === ebytes, {tag, " bytes"}, 32'(blk_bytes), 32'(ebytes));
    pulse_done();
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (blk_req) seen = 1;
      @(negedge clk);
    end
    chk(!seen, tag, 32'(seen), 32'h0);
  endtask

  initial begin
    #900000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; blk_done = 0; bus_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk(d == 0, "R1 reset readback", d, 0);
    end
    chk(blk_req === 1'b0, "R1 reset blk_req", 32'(blk_req), 0);

    // R2 start rules
    wr(4'd0, 32'h0);
    wr(4'd2, 32'd32);
    quiet(4, "R2 disabled length write starts nothing");
    rd(4'd2, d); chk(d == 32, "R2 length stored while disabled", d, 32);
    rd(4'd8, d); chk(d[1:0] == 0, "R2 not active", d, 0);
    wr(4'd0, 32'h1);
    quiet(4, "R2 enable alone starts nothing");
    wr(4'd2, 32'd0);
    quiet(4, "R2 zero length starts nothing");
    wr(4'd2, 32'd16);
    serve(1'b0, 32'h0, 5'd16, "R2 start after enabled write");

    // R3/R4 priority table
    for (int r = 0; r < 4; r++) begin
      wr(4'd9, 32'h1);
      wr(4'd0, {30'b0, ROWS[r][2], 1'b1});
      wr(4'd4, {30'b0, ROWS[r][1], 1'b1});
      wr(4'd1, 32'h100);
      wr(4'd5, 32'h200);
      wr(4'd2, 32'd40);
      wr(4'd6, 32'd40);
      await_req();
      chk(blk_ch === 1'b0, "R3 R4 first grant uncontested", 32'(blk_ch), 0);
      pulse_done();
      await_req();
      chk(blk_ch === ROWS[r][0], "R3 R4 contested grant", 32'(blk_ch), 32'(ROWS[r][0]));
      wr(4'd9, 32'h1);
      pulse_done();
      quiet(3, "R9 no request after soft reset");
    end

    // R4 round robin sequence
    wr(4'd9, 32'h1);
    wr(4'd0, 32'h1); wr(4'd4, 32'h1);
    wr(4'd1, 32'h1000); wr(4'd5, 32'h2000);
    wr(4'd2, 32'd48);
    wr(4'd6, 32'd48);
    serve(1'b0, 32'h1000, 5'd16, "R4 rr 1");
    serve(1'b0, 32'h1010, 5'd16, "R4 rr 2");
    serve(1'b1, 32'h2000, 5'd16, "R4 rr 3");
    serve(1'b0, 32'h1020, 5'd16, "R4 rr 4");
    serve(1'b1, 32'h2010, 5'd16, "R4 rr 5");
    serve(1'b1, 32'h2020, 5'd16, "R4 rr 6");
    rd(4'd8, d); chk(d == 32'h10, "R6 R8 both idle last ch1", d, 32'h10);

    // R5 partial tail, R10 bus error
    wr(4'd9, 32'h1);
    wr(4'd0, 32'h1); wr(4'd1, 32'h300); wr(4'd2, 32'd20);
    await_req();
    bus_err = 1'b1; @(negedge clk); bus_err = 1'b0;
    serve(1'b0, 32'h300, 5'd16, "R5 first block");
    rd(4'd1, d); chk(d == 32'h310, "R5 address readback", d, 32'h310);
    rd(4'd2, d); chk(d == 32'd4, "R5 length readback", d, 4);
    rd(4'd8, d); chk(d[8] == 1'b1, "R10 error latched", d, 32'h100);
    serve(1'b0, 32'h310, 5'd4, "R5 tail block");
    rd(4'd2, d); chk(d == 0, "R6 length zero", d, 0);
    rd(4'd8, d); chk(d == 32'h100, "R6 R8 R10 inactive last ch0 err kept", d, 32'h100);
    wr(4'd9, 32'h1);
    rd(4'd8, d); chk(d[8] == 1'b0, "R10 error cleared by soft reset", d, 0);

    // R7 disable mid-block
    wr(4'd0, 32'h1); wr(4'd1, 32'h400); wr(4'd2, 32'd64);
    await_req();
    wr(4'd0, 32'h0);
    chk(blk_req === 1'b1 && blk_addr == 32'h400, "R7 block held after disable", blk_addr, 32'h400);
    rd(4'd8, d); chk(d[0] == 1'b1, "R7 active while in flight", d, 1);
    pulse_done();
    quiet(5, "R7 no further request");
    rd(4'd8, d); chk(d[0] == 1'b0, "R7 inactive after block", d, 0);
    rd(4'd2, d); chk(d == 48, "R7 length after block", d, 48);

    // R9 soft reset with block in flight
    wr(4'd4, 32'h1); wr(4'd5, 32'h500); wr(4'd6, 32'd32);
    await_req();
    chk(blk_ch === 1'b1, "R9 ch1 granted", 32'(blk_ch), 1);
    wr(4'd9, 32'h1);
    rd(4'd9, d); chk(d == 0, "R9 reset bit reads zero", d, 0);
    rd(4'd4, d); chk(d == 0, "R9 enable cleared", d, 0);
    rd(4'd8, d); chk(d[1] == 1'b1, "R9 busy until block done", d, 2);
    chk(blk_req === 1'b1, "R9 R11 in-flight block kept", 32'(blk_req), 1);
    pulse_done();
    quiet(3, "R9 no request after reset done");
    rd(4'd8, d); chk(d[1:0] == 2'b00, "R9 both inactive", d, 0);

    finished = 1;
    summary();
  end
endmodule